// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block watches the BCD calendar fields of a time counter and raises an alarm when the programmed instant arrives. It has six compare registers: seconds, minutes, hours, weekday, day of month and month. Each register holds a BCD target in its low bits and a per-field enable in its top bit. A field whose enable is clear acts as a wildcard, so an alarm can fire, for example, every day at a given hour and minute.

The time counter pulses `sec_tick` in each cycle where its fields carry a freshly updated value. The match is evaluated only in that cycle. A hit sets a sticky alarm flag. The interrupt request is the flag gated by an alarm interrupt enable. Software reaches the compare registers and the control byte through a small write port with a combinational read-back. Before it reprograms the targets, software clears both the flag and the interrupt enable.

Top module: `cal_alarm_unit`

## Requirements
- R1: After reset, all six compare registers read 0x00, the control byte reads 0x00, and `alarm_flag` and `alarm_irq` are low.
- R2: Register indices are fixed: 8 is seconds, 9 is minutes, 10 is hours, 11 is weekday, 12 is day of month, 13 is month. Each of these reads back the full byte last written to it. Index 14 is control. It reads the flag at bit 0 and the interrupt enable at bit 3, with all other bits 0. Other indices read 0x00, and writes to them change nothing.
- R3: Bit 7 of a compare byte enables that field. Bits 6:0 hold the BCD target, which is compared with the 7-bit calendar field. Any difference in an enabled field prevents the alarm.
- R4: A field with bit 7 clear is ignored in the match. Writing 0x00 to a compare register disables that field.
- R5: The month target uses the 1 to 12 BCD encoding of the calendar input, so 0x12 matches December and does not match 0x02.
- R6: A match is evaluated only in a cycle with `sec_tick` high. The flag is high from the next clock edge onward. A calendar that keeps matching without a tick never sets the flag again after it has been cleared.
- R7: When no field is enabled, a tick never sets the flag.
- R8: Writing the control byte with bit 0 = 0 clears the flag. Writing bit 0 = 1 never sets it. A match arriving in the same cycle as a clear wins, and the flag stays set.
- R9: `alarm_irq` is high exactly when the flag and the interrupt enable (control bit 3) are both set. It is held as a level until either one is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | Calendar fields updated this cycle |
| cal_sec | input | 7 | Current seconds, BCD |
| cal_min | input | 7 | Current minutes, BCD |
| cal_hour | input | 7 | Current hours, BCD |
| cal_wday | input | 7 | Current weekday, BCD |
| cal_mday | input | 7 | Current day of month, BCD |
| cal_month | input | 7 | Current month 1-12, BCD |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Alarm interrupt request, level |

## Verification
Read-back is combinational, so a register write is visible one clock edge after `reg_we` is sampled. A tick sampled at an edge shows on `alarm_flag` and `alarm_irq` directly after that same edge. A flag or enable change from a control write reaches `alarm_irq` after one edge. The bench drives every input on the falling edge and samples on the following falling edge, so each result is read half a cycle after the edge that produced it. For the no-tick case, the bench waits several full cycles before it checks that nothing changed.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int N_FIELDS  = 6;
  localparam int FIELD_IDX = 8;   // seconds at 8 ... month at 13
  localparam int CTRL_IDX  = 14;
  localparam int FLAG_BIT  = 0;
  localparam int IE_BIT    = 3;

  typedef enum int {
    F_SEC = 0, F_MIN = 1, F_HOUR = 2, F_WDAY = 3, F_MDAY = 4, F_MONTH = 5
  } field_e;
endpackage

// File: rtl/cal_alarm_field.sv
module cal_alarm_field #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-2:0] cur_val,
  output logic [DATA_W-1:0] cfg_q,
  output logic              enabled,
  output logic              hit
);
  logic [DATA_W-1:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign enabled = cfg_q[DATA_W-1];
  assign hit     = !enabled || (cfg_q[DATA_W-2:0] == cur_val);

  assert_field_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cfg_q == $past(wdata));

  assert_field_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q));
endmodule

// File: rtl/cal_alarm_ctrl.sv
module cal_alarm_ctrl
  import cal_alarm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              match,
  input  logic              ctrl_we,
  input  logic [DATA_W-1:0] wdata,
  output logic              flag_q,
  output logic              ie_q,
  output logic              irq
);
  logic flag_d, ie_d, fire;

  assign fire = tick && match;

  always_comb begin
    flag_d = flag_q;
    ie_d   = ie_q;
    if (ctrl_we) begin
      ie_d = wdata[IE_BIT];
      if (!wdata[FLAG_BIT]) flag_d = 1'b0;
    end
    if (fire) flag_d = 1'b1;  // a hardware event beats a software clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      flag_q <= flag_d;
      ie_q   <= ie_d;
    end
  end

  assign irq = flag_q && ie_q;

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && match) |=> flag_q);

  assert_flag_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(tick && match));

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !ctrl_we) |=> flag_q);

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !wdata[FLAG_BIT] && !(tick && match)) |=> !flag_q);
endmodule

// File: rtl/cal_alarm_unit.sv
module cal_alarm_unit
  import cal_alarm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic [DATA_W-2:0] cal_sec,
  input  logic [DATA_W-2:0] cal_min,
  input  logic [DATA_W-2:0] cal_hour,
  input  logic [DATA_W-2:0] cal_wday,
  input  logic [DATA_W-2:0] cal_mday,
  input  logic [DATA_W-2:0] cal_month,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              alarm_flag,
  output logic              alarm_irq
);
  logic [DATA_W-2:0] cal_vec [N_FIELDS];
  logic [DATA_W-1:0] cfg_vec [N_FIELDS];
  logic [N_FIELDS-1:0] en_vec, hit_vec;
  logic match_all, ctrl_we, ie;

  assign cal_vec[F_SEC]   = cal_sec;
  assign cal_vec[F_MIN]   = cal_min;
  assign cal_vec[F_HOUR]  = cal_hour;
  assign cal_vec[F_WDAY]  = cal_wday;
  assign cal_vec[F_MDAY]  = cal_mday;
  assign cal_vec[F_MONTH] = cal_month;

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
    logic sel_we;
    assign sel_we = reg_we && (reg_addr == ADDR_W'(FIELD_IDX + g));
    cal_alarm_field #(.DATA_W(DATA_W)) u_field (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (sel_we),
      .wdata   (reg_wdata),
      .cur_val (cal_vec[g]),
      .cfg_q   (cfg_vec[g]),
      .enabled (en_vec[g]),
      .hit     (hit_vec[g])
    );
  end

  // at least one enabled field, and every enabled field equal
  assign match_all = (|en_vec) && (&hit_vec);
  assign ctrl_we   = reg_we && (reg_addr == ADDR_W'(CTRL_IDX));

  cal_alarm_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (sec_tick),
    .match   (match_all),
    .ctrl_we (ctrl_we),
    .wdata   (reg_wdata),
    .flag_q  (alarm_flag),
    .ie_q    (ie),
    .irq     (alarm_irq)
  );

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < N_FIELDS; i++)
      if (reg_addr == ADDR_W'(FIELD_IDX + i)) reg_rdata = cfg_vec[i];
    if (reg_addr == ADDR_W'(CTRL_IDX)) begin
      reg_rdata[FLAG_BIT] = alarm_flag;
      reg_rdata[IE_BIT]   = ie;
    end
  end

  assert_no_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_vec == '0 && !alarm_flag) |=> !alarm_flag);

  assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_irq && !reg_we) |=> alarm_irq);
endmodule

// File: tb/cal_alarm_unit_bench.sv
module cal_alarm_unit_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic sec_tick;
  logic [6:0] cal_sec, cal_min, cal_hour, cal_wday, cal_mday, cal_month;
  logic reg_we;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic alarm_flag, alarm_irq;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  cal_alarm_unit u_cal_alarm_unit (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .cal_sec(cal_sec), .cal_min(cal_min), .cal_hour(cal_hour),
    .cal_wday(cal_wday), .cal_mday(cal_mday), .cal_month(cal_month),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [3:0] a, input int exp);
    @(negedge clk); reg_addr = a; #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic set_cal(input logic [6:0] s, mi, h, w, d, mo);
    cal_sec = s; cal_min = mi; cal_hour = h; cal_wday = w; cal_mday = d; cal_month = mo;
  endtask

  task automatic clear_all();
    wr(4'd14, 8'h00);
    for (int i = 8; i < 14; i++) wr(4'(i), 8'h00);
  endtask

  task automatic t_reset();
    for (int i = 8; i < 15; i++) rd("R1 reg", 4'(i), 0);
    chk("R1 flag", alarm_flag, 0);
    chk("R1 irq", alarm_irq, 0);
  endtask

  task automatic t_regmap();
    for (int i = 8; i < 14; i++) wr(4'(i), 8'(8'h81 + i));
    for (int i = 8; i < 14; i++) rd("R2 readback", 4'(i), 8'h81 + i);
    wr(4'd3, 8'hAA);
    rd("R2 unmapped", 4'd3, 0);
    wr(4'd14, 8'hFF);
    rd("R2 ctrl mask", 4'd14, 8'h08);
    chk("R8 write 1 no set", alarm_flag, 0);
    clear_all();
  endtask

  task automatic t_full_match();
    set_cal(7'h30, 7'h15, 7'h23, 7'h05, 7'h31, 7'h12);
    wr(4'd8, 8'hB0); wr(4'd9, 8'h95); wr(4'd10, 8'hA3);
    wr(4'd11, 8'h85); wr(4'd12, 8'hB1); wr(4'd13, 8'h92);
    tick();
    chk("R3 full match", alarm_flag, 1);
    chk("R9 irq gated", alarm_irq, 0);
    wr(4'd14, 8'h00);
    cal_sec = 7'h31;
    tick();
    chk("R3 sec differs", alarm_flag, 0);
    cal_sec = 7'h30; cal_hour = 7'h22;
    tick();
    chk("R3 hour differs", alarm_flag, 0);
    clear_all();
  endtask

  task automatic t_wildcard();
    set_cal(7'h31, 7'h44, 7'h07, 7'h02, 7'h09, 7'h03);
    wr(4'd8, 8'hB1);
    tick();
    chk("R4 wildcard", alarm_flag, 1);
    wr(4'd14, 8'h00);
    wr(4'd8, 8'h00);
    rd("R4 zero disables", 4'd8, 0);
    tick();
    chk("R7 none enabled", alarm_flag, 0);
  endtask

  task automatic t_month();
    set_cal(7'h00, 7'h00, 7'h00, 7'h00, 7'h01, 7'h12);
    wr(4'd13, 8'h92);
    tick();
    chk("R5 december", alarm_flag, 1);
    wr(4'd14, 8'h00);
    cal_month = 7'h02;
    tick();
    chk("R5 february", alarm_flag, 0);
    cal_month = 7'h12;
    repeat (5) @(negedge clk);
    chk("R6 no tick", alarm_flag, 0);
    tick();
    chk("R6 tick sets", alarm_flag, 1);
  endtask

  task automatic t_ctrl();
    wr(4'd14, 8'h09);
    chk("R9 irq on", alarm_irq, 1);
    chk("R8 keep with 1", alarm_flag, 1);
    repeat (3) @(negedge clk);
    chk("R9 irq level", alarm_irq, 1);
    wr(4'd14, 8'h01);
    chk("R9 ie off", alarm_irq, 0);
    chk("R9 flag stays", alarm_flag, 1);
    wr(4'd14, 8'h00);
    chk("R8 clear", alarm_flag, 0);
    @(negedge clk);
    sec_tick = 1'b1; reg_we = 1'b1; reg_addr = 4'd14; reg_wdata = 8'h00;
    @(negedge clk);
    sec_tick = 1'b0; reg_we = 1'b0;
    chk("R8 set beats clear", alarm_flag, 1);
    clear_all();
  endtask

  initial begin
    rst_n = 1'b0; sec_tick = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    set_cal('0, '0, '0, '0, '0, '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_full_match();
    t_wildcard();
    t_month();
    t_ctrl();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule